// File: doc/BRIEF.md
# Converter Power-Up Settling Sequencer

This block gates the data of a stereo ADC path and a stereo DAC path while the converters settle after they are switched on. It watches three power-enable inputs: one for the left ADC channel, one for the right ADC channel, and one for the DAC. It also receives a strobe that pulses once per audio sample period. When a path is switched on while the opposite path is fully off, the block holds both channels of that path at two's-complement zero for a fixed number of sample periods. After that it passes the real samples through.

When a path is switched on while the opposite path is already running, the settling wait is skipped and data flows at once. A per-path ready output tells the surrounding logic when the path carries valid samples. Switching a path off abandons its wait. A synchronous active-high reset returns all state to idle.

Top module: `conv_init_seq`

## Requirements
- R1: A 0-to-1 change on the left or the right ADC enable, sampled while the DAC enable is 0, starts ADC settling. From the cycle in which the change is seen, `adc_ready` is 0 and both ADC outputs are 0 for the whole settling period.
- R2: Settling lasts exactly INIT_PERIODS sample strobes (default 1059). Only strobes sampled on clock edges after the one that registers the start are counted. Ready rises on the edge that samples the INIT_PERIODS-th such strobe. Clock cycles without a strobe do not shorten the wait.
- R3: A 0-to-1 change on the DAC enable, sampled while both ADC enables are 0, starts DAC settling. During it, `dac_ready` is 0 and both DAC outputs are 0.
- R4: An ADC enable that rises while the DAC enable is 1 starts no settling: `adc_ready` is 1 in that same cycle. This holds even while the DAC itself is still settling.
- R5: A DAC enable rise while either ADC enable is 1 starts no settling: `dac_ready` is 1 in that same cycle.
- R6: When the DAC enable and an ADC enable rise in the same cycle, each sees the other as active, and neither path settles.
- R7: A rise of the second ADC channel's enable while the DAC enable is 0 restarts the ADC count from zero. This applies even when the first ADC channel is already on.
- R8: If a path is switched off during settling (for the ADC path, both ADC enables at 0), the count is dropped. A later enable rise starts a fresh, full-length count.
- R9: A ready output is 1 only while its path is enabled and not settling. Whenever the path is ready or disabled, its outputs equal its inputs.
- R10: `rst` high at a clock edge clears all state. Enables that are still high when `rst` falls count as new rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fs_tick | input | 1 | One-cycle pulse per sample period |
| adc_en_l | input | 1 | Left ADC power enable |
| adc_en_r | input | 1 | Right ADC power enable |
| dac_en | input | 1 | DAC power enable |
| adc_l_in | input | DATA_W | Left sample from the ADC |
| adc_r_in | input | DATA_W | Right sample from the ADC |
| dac_l_in | input | DATA_W | Left sample toward the DAC |
| dac_r_in | input | DATA_W | Right sample toward the DAC |
| adc_l_out | output | DATA_W | Gated left ADC sample |
| adc_r_out | output | DATA_W | Gated right ADC sample |
| dac_l_out | output | DATA_W | Gated left DAC sample |
| dac_r_out | output | DATA_W | Gated right DAC sample |
| adc_ready | output | 1 | ADC path enabled and settled |
| dac_ready | output | 1 | DAC path enabled and settled |

## Verification
The properties assume that the enables and `fs_tick` change only between clock edges. They also assume the enables are at known values before reset is released, so that a rise seen just after reset is a real rise. The stimulus changes every input on the falling clock edge and holds the enables low, or at fixed levels, across reset. Strobes are issued one at a time and counted by the bench. This lets the exact settling boundary be reached one strobe short and then one strobe on.

// File: rtl/conv_init_pkg.sv
package conv_init_pkg;

    localparam int unsigned SETTLE_PERIODS_DEF = 1059;
    localparam int unsigned SAMPLE_W_DEF       = 16;

    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_SETTLE = 1'b1
    } settle_phase_e;

    typedef struct packed {
        logic adc_l;
        logic adc_r;
        logic dac;
    } pwr_req_t;

    function automatic logic adc_any(input pwr_req_t req);
        return req.adc_l | req.adc_r;
    endfunction

    function automatic logic adc_trigger(input pwr_req_t now, input pwr_req_t was);
        return ((now.adc_l & ~was.adc_l) | (now.adc_r & ~was.adc_r)) & ~now.dac;
    endfunction

    function automatic logic dac_trigger(input pwr_req_t now, input pwr_req_t was);
        return now.dac & ~was.dac & ~adc_any(now);
    endfunction

endpackage

// File: rtl/pwr_edge_detect.sv
module pwr_edge_detect
    import conv_init_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pwr_req_t req,
    output logic     adc_start,
    output logic     dac_start
);

    pwr_req_t req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else begin
            req_q <= req;
        end
    end

    always_comb begin
        adc_start = adc_trigger(req, req_q);
        dac_start = dac_trigger(req, req_q);
    end

endmodule

// File: rtl/settle_timer.sv
module settle_timer
    import conv_init_pkg::*;
#(
    parameter int unsigned PERIODS = SETTLE_PERIODS_DEF,
    parameter int unsigned CNT_W   = $clog2(PERIODS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic fs_tick,
    input  logic start,
    input  logic path_on,
    output logic hold
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIODS - 1);

    settle_phase_e    phase;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (start) begin
            phase <= PH_SETTLE;
            cnt   <= '0;
        end else if (!path_on) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (phase == PH_SETTLE && fs_tick) begin
            if (cnt == LAST) begin
                phase <= PH_IDLE;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign hold = start | ((phase == PH_SETTLE) & path_on);

endmodule

// File: rtl/zero_gate.sv
module zero_gate #(
    parameter int unsigned W = 16
) (
    input  logic         hold,
    input  logic [W-1:0] in_l,
    input  logic [W-1:0] in_r,
    output logic [W-1:0] out_l,
    output logic [W-1:0] out_r
);

    assign out_l = hold ? '0 : in_l;
    assign out_r = hold ? '0 : in_r;

endmodule

// File: rtl/conv_init_seq.sv
module conv_init_seq
    import conv_init_pkg::*;
#(
    parameter int unsigned DATA_W       = SAMPLE_W_DEF,
    parameter int unsigned INIT_PERIODS = SETTLE_PERIODS_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fs_tick,
    input  logic              adc_en_l,
    input  logic              adc_en_r,
    input  logic              dac_en,
    input  logic [DATA_W-1:0] adc_l_in,
    input  logic [DATA_W-1:0] adc_r_in,
    input  logic [DATA_W-1:0] dac_l_in,
    input  logic [DATA_W-1:0] dac_r_in,
    output logic [DATA_W-1:0] adc_l_out,
    output logic [DATA_W-1:0] adc_r_out,
    output logic [DATA_W-1:0] dac_l_out,
    output logic [DATA_W-1:0] dac_r_out,
    output logic              adc_ready,
    output logic              dac_ready
);

    localparam int unsigned CNT_W = $clog2(INIT_PERIODS + 1);

    pwr_req_t req;
    logic     adc_start, dac_start;
    logic     adc_on, dac_on;
    logic     adc_hold, dac_hold;

    assign req    = '{adc_l: adc_en_l, adc_r: adc_en_r, dac: dac_en};
    assign adc_on = adc_any(req);
    assign dac_on = dac_en;

    pwr_edge_detect u_edge (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .adc_start (adc_start),
        .dac_start (dac_start)
    );

    settle_timer #(.PERIODS(INIT_PERIODS), .CNT_W(CNT_W)) u_adc_timer (
        .clk     (clk),
        .rst     (rst),
        .fs_tick (fs_tick),
        .start   (adc_start),
        .path_on (adc_on),
        .hold    (adc_hold)
    );

    settle_timer #(.PERIODS(INIT_PERIODS), .CNT_W(CNT_W)) u_dac_timer (
        .clk     (clk),
        .rst     (rst),
        .fs_tick (fs_tick),
        .start   (dac_start),
        .path_on (dac_on),
        .hold    (dac_hold)
    );

    zero_gate #(.W(DATA_W)) u_adc_gate (
        .hold  (adc_hold),
        .in_l  (adc_l_in),
        .in_r  (adc_r_in),
        .out_l (adc_l_out),
        .out_r (adc_r_out)
    );

    zero_gate #(.W(DATA_W)) u_dac_gate (
        .hold  (dac_hold),
        .in_l  (dac_l_in),
        .in_r  (dac_r_in),
        .out_l (dac_l_out),
        .out_r (dac_r_out)
    );

    assign adc_ready = adc_on & ~adc_hold;
    assign dac_ready = dac_on & ~dac_hold;

endmodule

// File: rtl/conv_init_seq_chk.sv
module conv_init_seq_chk #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              adc_en_l,
    input logic              adc_en_r,
    input logic              dac_en,
    input logic [DATA_W-1:0] adc_l_in,
    input logic [DATA_W-1:0] adc_r_in,
    input logic [DATA_W-1:0] dac_l_in,
    input logic [DATA_W-1:0] dac_r_in,
    input logic [DATA_W-1:0] adc_l_out,
    input logic [DATA_W-1:0] adc_r_out,
    input logic [DATA_W-1:0] dac_l_out,
    input logic [DATA_W-1:0] dac_r_out,
    input logic              adc_ready,
    input logic              dac_ready
);

    // R1
    adc_settle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ((adc_en_l || adc_en_r) && !adc_ready) |-> (adc_l_out == '0 && adc_r_out == '0));

    // R3
    dac_settle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (dac_en && !dac_ready) |-> (dac_l_out == '0 && dac_r_out == '0));

    // R4
    adc_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (($rose(adc_en_l) || $rose(adc_en_r)) && dac_en) |-> adc_ready);

    // R5
    dac_skip_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(dac_en) && (adc_en_l || adc_en_r)) |-> dac_ready);

    // R9
    adc_ready_en_chk: assert property (@(posedge clk) disable iff (rst)
        adc_ready |-> ((adc_en_l || adc_en_r) && adc_l_out == adc_l_in && adc_r_out == adc_r_in));

    // R9
    dac_ready_en_chk: assert property (@(posedge clk) disable iff (rst)
        dac_ready |-> (dac_en && dac_l_out == dac_l_in && dac_r_out == dac_r_in));

    // R9
    adc_off_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (!adc_en_l && !adc_en_r) |-> (adc_l_out == adc_l_in && adc_r_out == adc_r_in));

endmodule

bind conv_init_seq conv_init_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .adc_en_l  (adc_en_l),
    .adc_en_r  (adc_en_r),
    .dac_en    (dac_en),
    .adc_l_in  (adc_l_in),
    .adc_r_in  (adc_r_in),
    .dac_l_in  (dac_l_in),
    .dac_r_in  (dac_r_in),
    .adc_l_out (adc_l_out),
    .adc_r_out (adc_r_out),
    .dac_l_out (dac_l_out),
    .dac_r_out (dac_r_out),
    .adc_ready (adc_ready),
    .dac_ready (dac_ready)
);

// File: tb/conv_init_seq_bench.sv
`timescale 1ns/1ps
module conv_init_seq_bench;

    localparam int W = 16;
    localparam int N = 1059;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         fs_tick = 1'b0;
    logic         adc_en_l = 1'b0, adc_en_r = 1'b0, dac_en = 1'b0;
    logic [W-1:0] adc_l_in = 16'h1234, adc_r_in = 16'hA5A5;
    logic [W-1:0] dac_l_in = 16'h7FFF, dac_r_in = 16'h8000;
    logic [W-1:0] adc_l_out, adc_r_out, dac_l_out, dac_r_out;
    logic         adc_ready, dac_ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    conv_init_seq u_conv_init_seq (
        .clk(clk), .rst(rst), .fs_tick(fs_tick),
        .adc_en_l(adc_en_l), .adc_en_r(adc_en_r), .dac_en(dac_en),
        .adc_l_in(adc_l_in), .adc_r_in(adc_r_in),
        .dac_l_in(dac_l_in), .dac_r_in(dac_r_in),
        .adc_l_out(adc_l_out), .adc_r_out(adc_r_out),
        .dac_l_out(dac_l_out), .dac_r_out(dac_r_out),
        .adc_ready(adc_ready), .dac_ready(dac_ready)
    );

    typedef struct packed {
        logic        l;
        logic        r;
        logic        d;
        logic [11:0] ticks;
        logic        exp_adc;
        logic        exp_dac;
    } step_t;

    localparam int NSTEP = 20;
    localparam step_t STEPS [NSTEP] = '{
        '{1'b1, 1'b0, 1'b0, 12'd0,    1'b0, 1'b0},  // R1 ADC starts settling
        '{1'b1, 1'b0, 1'b0, 12'd1058, 1'b0, 1'b0},  // R2 one strobe short
        '{1'b1, 1'b0, 1'b0, 12'd1,    1'b1, 1'b0},  // R2 boundary
        '{1'b1, 1'b0, 1'b1, 12'd0,    1'b1, 1'b1},  // R5 DAC skip
        '{1'b0, 1'b0, 1'b1, 12'd0,    1'b0, 1'b1},
        '{1'b0, 1'b1, 1'b1, 12'd0,    1'b1, 1'b1},  // R4 ADC skip
        '{1'b0, 1'b0, 1'b0, 12'd0,    1'b0, 1'b0},
        '{1'b0, 1'b0, 1'b1, 12'd0,    1'b0, 1'b0},  // R3 DAC settling
        '{1'b0, 1'b0, 1'b1, 12'd1058, 1'b0, 1'b0},  // R3 one short
        '{1'b1, 1'b0, 1'b1, 12'd0,    1'b1, 1'b0},  // R4 skip while DAC settles
        '{1'b1, 1'b0, 1'b1, 12'd1,    1'b1, 1'b1},  // R2 DAC boundary
        '{1'b0, 1'b0, 1'b0, 12'd0,    1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b0, 12'd500,  1'b0, 1'b0},  // R8 partial count
        '{1'b0, 1'b0, 1'b0, 12'd0,    1'b0, 1'b0},  // R8 abort
        '{1'b0, 1'b1, 1'b0, 12'd1058, 1'b0, 1'b0},  // R8 fresh count
        '{1'b0, 1'b1, 1'b0, 12'd1,    1'b1, 1'b0},  // R8 completes
        '{1'b1, 1'b1, 1'b0, 12'd0,    1'b0, 1'b0},  // R7 restart
        '{1'b1, 1'b1, 1'b1, 12'd1059, 1'b1, 1'b1},  // R7 full new count, R5
        '{1'b0, 1'b0, 1'b0, 12'd0,    1'b0, 1'b0},
        '{1'b1, 1'b0, 1'b1, 12'd0,    1'b1, 1'b1}   // R6 simultaneous
    };

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_word(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // R9: outputs zero while enabled and not ready, otherwise equal to inputs
    task automatic check_data(input string req);
        logic adc_zero, dac_zero;
        adc_zero = (adc_en_l | adc_en_r) & ~adc_ready;
        dac_zero = dac_en & ~dac_ready;
        check_word({req, " R9 adc_l"}, adc_l_out, adc_zero ? '0 : adc_l_in);
        check_word({req, " R9 adc_r"}, adc_r_out, adc_zero ? '0 : adc_r_in);
        check_word({req, " R9 dac_l"}, dac_l_out, dac_zero ? '0 : dac_l_in);
        check_word({req, " R9 dac_r"}, dac_r_out, dac_zero ? '0 : dac_r_in);
    endtask

    task automatic strobes(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) fs_tick = 1'b1;
            @(negedge clk) fs_tick = 1'b0;
        end
    endtask

    always @(posedge clk) begin : watchdog
        int cyc;
        cyc++;
        if (cyc > 150000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check_bit("R10 adc_ready after reset", adc_ready, 1'b0);
        check_bit("R10 dac_ready after reset", dac_ready, 1'b0);
        check_data("R10");

        for (int i = 0; i < NSTEP; i++) begin
            adc_en_l = STEPS[i].l;
            adc_en_r = STEPS[i].r;
            dac_en   = STEPS[i].d;
            #0.1;
            // the rise is gated in the same cycle it appears
            if (STEPS[i].ticks == 0) begin
                check_bit($sformatf("step %0d R1/R4 adc_ready early", i), adc_ready, STEPS[i].exp_adc);
                check_bit($sformatf("step %0d R3/R5 dac_ready early", i), dac_ready, STEPS[i].exp_dac);
            end
            @(negedge clk);
            strobes(int'(STEPS[i].ticks));
            check_bit($sformatf("step %0d R2 adc_ready", i), adc_ready, STEPS[i].exp_adc);
            check_bit($sformatf("step %0d R2 dac_ready", i), dac_ready, STEPS[i].exp_dac);
            check_data($sformatf("step %0d", i));
        end

        // R2: idle clocks without strobes do not advance the count
        adc_en_l = 1'b0; adc_en_r = 1'b0; dac_en = 1'b0;
        @(negedge clk);
        adc_en_l = 1'b1;
        @(negedge clk);
        strobes(N - 1);
        repeat (2000) @(negedge clk);
        check_bit("R2 no strobe no progress", adc_ready, 1'b0);
        strobes(1);
        check_bit("R2 final strobe", adc_ready, 1'b1);

        // R10: reset mid-count with the enable held restarts settling
        adc_en_l = 1'b0;
        @(negedge clk);
        adc_en_l = 1'b1;
        @(negedge clk);
        strobes(N - 1);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_bit("R10 restart after reset", adc_ready, 1'b0);
        strobes(N - 1);
        check_bit("R10 still settling", adc_ready, 1'b0);
        check_data("R10");
        strobes(1);
        check_bit("R10 settled", adc_ready, 1'b1);

        // R1: new sample values pass once ready
        adc_l_in = 16'hFFFF;
        adc_r_in = 16'h0001;
        #0.1;
        check_data("R1 new data");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule